// File: doc/BRIEF.md
# Descriptor-Based Address Router

This block decides where a memory or I/O access goes. It holds a small bank of programmable descriptors. Each descriptor has a kind, a destination port number and up to three address words. Configuration logic loads a whole descriptor in one cycle through a write port. Every lookup presents an address and a flag that says whether the access is memory or I/O. The block answers one clock later. The answer is the destination port, the address to forward (translated when the descriptor carries an offset) and a flag that marks the default route.

Several descriptor kinds are supported. Memory page-range windows and power-of-two windows can each translate the address by adding an offset. Hole-map descriptors split a fixed, aligned region into equal slices. A per-slice bit sends each slice either to the descriptor's port or to the default port. Any access that no descriptor claims takes the default port, which leads toward the PCI side. Overlapping descriptors are a programming error. When they overlap, the block settles the result by index order and raises a flag.

Top module: `desc_route_dec`

## Requirements
- R1: After reset every descriptor has kind 0 (disabled). A lookup that no descriptor claims returns port SUB_PORT, the default flag set, the request address unchanged, and the overlap flag clear.
- R2: Kind 1 (page range) claims a memory address whose 4 KB page number (address bits above bit 11) lies between the page numbers of word A and word B, both bounds inclusive. The address is forwarded unchanged.
- R3: Kind 2 (page range with offset) claims addresses as kind 1 does. It forwards the address plus the offset word, wrapping modulo 2^ADDR_W.
- R4: Kind 3 (memory base/mask) claims a memory address when (address XOR A) AND B is zero, where A is the base and B is the mask. The address is forwarded unchanged.
- R5: Kind 4 (memory base/mask with offset) claims addresses as kind 3 does and forwards the address plus the offset word.
- R6: Kind 5 (memory hole map) claims the 256 KB region whose address bits above bit 17 equal those of A. Address bits 17..14 select a slice, and bit B[slice] decides the route. A value of 1 sends the slice to the descriptor's port. A value of 0 sends it to port SUB_PORT with the default flag set. In both cases the address is unchanged.
- R7: Kind 6 (I/O base/mask) claims an I/O address under the same base/mask rule as R4.
- R8: Kind 7 (I/O hole map) claims the 8-byte region whose address bits above bit 2 equal those of A. B[address bits 2..0] routes each byte as in R6.
- R9: Kinds 1 to 5 never claim a lookup with req_io = 1. Kinds 6 and 7 never claim a lookup with req_io = 0.
- R10: When several descriptors claim an address, the lowest-numbered one sets the result and res_overlap is 1. Otherwise res_overlap is 0.
- R11: res_valid is 1 exactly in the cycle after a cycle with req_valid = 1. The result outputs hold their values in cycles with no request.
- R12: A descriptor write takes effect for lookups issued in the following cycle. A lookup issued in the same cycle as the write uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one descriptor |
| cfg_idx | input | IDX_W | Descriptor number to write |
| cfg_kind | input | 3 | Descriptor kind (0 to 7, see R1 to R8) |
| cfg_port | input | PORT_W | Destination port of the descriptor |
| cfg_a | input | ADDR_W | Word A: start or base |
| cfg_b | input | ADDR_W | Word B: end, mask or slice bits |
| cfg_off | input | ADDR_W | Offset added by the translating kinds |
| req_valid | input | 1 | Lookup request |
| req_io | input | 1 | 1 for I/O space, 0 for memory space |
| req_addr | input | ADDR_W | Lookup address |
| res_valid | output | 1 | Result valid |
| res_port | output | PORT_W | Destination port |
| res_addr | output | ADDR_W | Forwarded address |
| res_sub | output | 1 | Default route taken |
| res_overlap | output | 1 | More than one descriptor claimed the address |

## Verification
A corrupted descriptor register stays hidden until a lookup lands on its window. The next result, one cycle after that lookup, then shows a wrong port, a wrong address or a missing default flag. For that reason, each descriptor kind is probed at its edges: the last and first pages of a range, the bytes just inside and just outside a mask window, and neighbouring slices of a hole map. Faults in the result register or the priority logic appear either as res_valid out of step with requests or as the wrong owner of a deliberately overlapped address, again on the next cycle.

// File: rtl/drd_pkg.sv
package drd_pkg;
   typedef enum logic [2:0] {
      K_OFF        = 3'd0,
      K_MRANGE     = 3'd1,
      K_MRANGE_OFS = 3'd2,
      K_MBM        = 3'd3,
      K_MBM_OFS    = 3'd4,
      K_MSLICE     = 3'd5,
      K_IOBM       = 3'd6,
      K_IOSLICE    = 3'd7
   } dkind_t;

   localparam int PAGE_SH     = 12;
   localparam int MSLICE_SH   = 14;
   localparam int MREGION_SH  = 18;
   localparam int IOREGION_SH = 3;
endpackage

// File: rtl/desc_slot.sv
module desc_slot
   import drd_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PORT_W   = 3,
   parameter int SUB_PORT = 0,
   parameter bit OFS_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  dkind_t            kind_i,
   input  logic [PORT_W-1:0] port_i,
   input  logic [ADDR_W-1:0] a_i,
   input  logic [ADDR_W-1:0] b_i,
   input  logic [ADDR_W-1:0] off_i,
   input  logic              lk_io,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              hit_o,
   output logic [PORT_W-1:0] port_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              sub_o
);
   dkind_t            kind_q;
   logic [PORT_W-1:0] port_q;
   logic [ADDR_W-1:0] a_q, b_q;
   logic [ADDR_W-1:0] ofs_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= K_OFF;
         port_q <= '0;
         a_q    <= '0;
         b_q    <= '0;
      end else if (we) begin
         kind_q <= kind_i;
         port_q <= port_i;
         a_q    <= a_i;
         b_q    <= b_i;
      end
   end

   generate
      if (OFS_EN) begin : g_ofs
         logic [ADDR_W-1:0] off_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  off_q <= '0;
            else if (we) off_q <= off_i;
         end
         assign ofs_addr = lk_addr + off_q;
      end else begin : g_no_ofs
         assign ofs_addr = lk_addr;
      end
   endgenerate

   logic in_rng, bm_eq, in_mreg, in_ioreg, mslice_bit, ioslice_bit;
   assign in_rng = (lk_addr[ADDR_W-1:PAGE_SH] >= a_q[ADDR_W-1:PAGE_SH]) &&
                   (lk_addr[ADDR_W-1:PAGE_SH] <= b_q[ADDR_W-1:PAGE_SH]);
   assign bm_eq       = ((lk_addr ^ a_q) & b_q) == '0;
   assign in_mreg     = lk_addr[ADDR_W-1:MREGION_SH] == a_q[ADDR_W-1:MREGION_SH];
   assign in_ioreg    = lk_addr[ADDR_W-1:IOREGION_SH] == a_q[ADDR_W-1:IOREGION_SH];
   assign mslice_bit  = b_q[lk_addr[MREGION_SH-1:MSLICE_SH]];
   assign ioslice_bit = b_q[lk_addr[IOREGION_SH-1:0]];

   always_comb begin
      hit_o  = 1'b0;
      sub_o  = 1'b0;
      addr_o = lk_addr;
      unique case (kind_q)
         K_MRANGE:     hit_o = !lk_io && in_rng;
         K_MRANGE_OFS: begin hit_o = !lk_io && in_rng; addr_o = ofs_addr; end
         K_MBM:        hit_o = !lk_io && bm_eq;
         K_MBM_OFS:    begin hit_o = !lk_io && bm_eq;  addr_o = ofs_addr; end
         K_MSLICE:     begin hit_o = !lk_io && in_mreg; sub_o = !mslice_bit; end
         K_IOBM:       hit_o = lk_io && bm_eq;
         K_IOSLICE:    begin hit_o = lk_io && in_ioreg; sub_o = !ioslice_bit; end
         default:      hit_o = 1'b0;
      endcase
      port_o = sub_o ? PORT_W'(SUB_PORT) : port_q;
   end
endmodule

// File: rtl/desc_pick.sv
module desc_pick #(
   parameter int NUM_DESC = 4,
   parameter int ADDR_W   = 32,
   parameter int PORT_W   = 3,
   parameter int SUB_PORT = 0
) (
   input  logic [NUM_DESC-1:0]             hit,
   input  logic [NUM_DESC-1:0][PORT_W-1:0] port_v,
   input  logic [NUM_DESC-1:0][ADDR_W-1:0] addr_v,
   input  logic [NUM_DESC-1:0]             sub_v,
   input  logic [ADDR_W-1:0]               req_addr,
   output logic [PORT_W-1:0]               port_o,
   output logic [ADDR_W-1:0]               addr_o,
   output logic                            sub_o,
   output logic                            ovl_o
);
   always_comb begin
      port_o = PORT_W'(SUB_PORT);
      addr_o = req_addr;
      sub_o  = 1'b1;
      for (int i = NUM_DESC - 1; i >= 0; i--) begin
         if (hit[i]) begin
            port_o = port_v[i];
            addr_o = addr_v[i];
            sub_o  = sub_v[i];
         end
      end
      ovl_o = $countones(hit) > 1;
   end
endmodule

// File: rtl/desc_route_dec.sv
module desc_route_dec
   import drd_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int NUM_DESC = 4,
   parameter int PORT_W   = 3,
   parameter int SUB_PORT = 0,
   parameter bit OFS_EN   = 1'b1,
   localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [2:0]        cfg_kind,
   input  logic [PORT_W-1:0] cfg_port,
   input  logic [ADDR_W-1:0] cfg_a,
   input  logic [ADDR_W-1:0] cfg_b,
   input  logic [ADDR_W-1:0] cfg_off,
   input  logic              req_valid,
   input  logic              req_io,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              res_valid,
   output logic [PORT_W-1:0] res_port,
   output logic [ADDR_W-1:0] res_addr,
   output logic              res_sub,
   output logic              res_overlap
);
   generate
      if (ADDR_W < MREGION_SH + 2) begin : g_bad_aw
         $error("ADDR_W too small for the hole-map region");
      end
      if (NUM_DESC < 2) begin : g_bad_nd
         $error("NUM_DESC must be at least 2");
      end
      if (SUB_PORT >= (1 << PORT_W)) begin : g_bad_sp
         $error("SUB_PORT does not fit in PORT_W");
      end
   endgenerate

   logic [NUM_DESC-1:0]             hit_v, sub_v;
   logic [NUM_DESC-1:0][PORT_W-1:0] port_v;
   logic [NUM_DESC-1:0][ADDR_W-1:0] addr_v;

   genvar g;
   generate
      for (g = 0; g < NUM_DESC; g++) begin : g_slot
         desc_slot #(
            .ADDR_W(ADDR_W), .PORT_W(PORT_W), .SUB_PORT(SUB_PORT), .OFS_EN(OFS_EN)
         ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (cfg_we && (cfg_idx == IDX_W'(g))),
            .kind_i (dkind_t'(cfg_kind)),
            .port_i (cfg_port),
            .a_i    (cfg_a),
            .b_i    (cfg_b),
            .off_i  (cfg_off),
            .lk_io  (req_io),
            .lk_addr(req_addr),
            .hit_o  (hit_v[g]),
            .port_o (port_v[g]),
            .addr_o (addr_v[g]),
            .sub_o  (sub_v[g])
         );
      end
   endgenerate

   logic [PORT_W-1:0] pk_port;
   logic [ADDR_W-1:0] pk_addr;
   logic              pk_sub, pk_ovl;

   desc_pick #(
      .NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .PORT_W(PORT_W), .SUB_PORT(SUB_PORT)
   ) u_pick (
      .hit     (hit_v),
      .port_v  (port_v),
      .addr_v  (addr_v),
      .sub_v   (sub_v),
      .req_addr(req_addr),
      .port_o  (pk_port),
      .addr_o  (pk_addr),
      .sub_o   (pk_sub),
      .ovl_o   (pk_ovl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_port    <= '0;
         res_addr    <= '0;
         res_sub     <= 1'b0;
         res_overlap <= 1'b0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            res_port    <= pk_port;
            res_addr    <= pk_addr;
            res_sub     <= pk_sub;
            res_overlap <= pk_ovl;
         end
      end
   end
endmodule

// File: rtl/desc_route_chk.sv
module desc_route_chk #(
   parameter int ADDR_W   = 32,
   parameter int PORT_W   = 3,
   parameter int SUB_PORT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              res_valid,
   input logic [PORT_W-1:0] res_port,
   input logic [ADDR_W-1:0] res_addr,
   input logic              res_sub
);
   p_req_gives_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   p_idle_no_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(res_port) && $stable(res_addr) && $stable(res_sub)));

   p_sub_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_sub) |-> (res_port == PORT_W'(SUB_PORT)));

   p_sub_addr_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!res_sub || (res_addr == $past(req_addr))));
endmodule

bind desc_route_dec desc_route_chk #(
   .ADDR_W(ADDR_W), .PORT_W(PORT_W), .SUB_PORT(SUB_PORT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_addr (req_addr),
   .res_valid(res_valid),
   .res_port (res_port),
   .res_addr (res_addr),
   .res_sub  (res_sub)
);

// File: tb/desc_route_dec_test.sv
module desc_route_dec_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [2:0]  cfg_kind = '0;
   logic [2:0]  cfg_port = '0;
   logic [31:0] cfg_a = '0, cfg_b = '0, cfg_off = '0;
   logic        req_valid = 1'b0, req_io = 1'b0;
   logic [31:0] req_addr = '0;
   logic        res_valid, res_sub, res_overlap;
   logic [2:0]  res_port;
   logic [31:0] res_addr;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   desc_route_dec uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_kind(cfg_kind),
      .cfg_port(cfg_port), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_off(cfg_off),
      .req_valid(req_valid), .req_io(req_io), .req_addr(req_addr),
      .res_valid(res_valid), .res_port(res_port), .res_addr(res_addr),
      .res_sub(res_sub), .res_overlap(res_overlap)
   );

   task automatic check_res(input logic ev, input logic [2:0] ep, input logic [31:0] ea,
                            input logic es, input logic eo, input string tag);
      n_chk++;
      if ({res_valid, res_port, res_addr, res_sub, res_overlap} !== {ev, ep, ea, es, eo}) begin
         n_bad++;
         $display("FAIL %s: got v=%0b port=%0d addr=%h sub=%0b ovl=%0b, exp v=%0b port=%0d addr=%h sub=%0b ovl=%0b",
                  tag, res_valid, res_port, res_addr, res_sub, res_overlap, ev, ep, ea, es, eo);
      end
   endtask

   task automatic set_cfg(input int idx, input logic [2:0] k, input logic [2:0] p,
                          input logic [31:0] a, input logic [31:0] b, input logic [31:0] o);
      cfg_idx = 2'(idx); cfg_kind = k; cfg_port = p; cfg_a = a; cfg_b = b; cfg_off = o;
      cfg_we = 1'b1;
   endtask

   task automatic wr(input int idx, input logic [2:0] k, input logic [2:0] p,
                     input logic [31:0] a, input logic [31:0] b, input logic [31:0] o);
      set_cfg(idx, k, p, a, b, o);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic look(input logic [31:0] a, input logic io, input logic [2:0] ep,
                       input logic [31:0] ea, input logic es, input logic eo, input string tag);
      req_addr = a; req_io = io; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check_res(1'b1, ep, ea, es, eo, tag);
   endtask

   task automatic t_reset;
      check_res(1'b0, 3'd0, 32'h0, 1'b0, 1'b0, "R1 reset outputs");
      look(32'h1234_5678, 1'b0, 3'd0, 32'h1234_5678, 1'b1, 1'b0, "R1 empty table mem");
      look(32'h0000_03F8, 1'b1, 3'd0, 32'h0000_03F8, 1'b1, 1'b0, "R1 empty table io");
   endtask

   task automatic t_range;
      wr(0, 3'd1, 3'd1, 32'h0010_0000, 32'h0010_2FFF, 32'h0);
      look(32'h0010_0000, 1'b0, 3'd1, 32'h0010_0000, 1'b0, 1'b0, "R2 first page");
      look(32'h0010_2FFC, 1'b0, 3'd1, 32'h0010_2FFC, 1'b0, 1'b0, "R2 last page");
      look(32'h0010_3000, 1'b0, 3'd0, 32'h0010_3000, 1'b1, 1'b0, "R2 above end");
      look(32'h000F_FFFF, 1'b0, 3'd0, 32'h000F_FFFF, 1'b1, 1'b0, "R2 below start");
   endtask

   task automatic t_offsets;
      wr(1, 3'd2, 3'd2, 32'h2000_0000, 32'h2000_0FFF, 32'hF000_0000);
      look(32'h2000_0010, 1'b0, 3'd2, 32'h1000_0010, 1'b0, 1'b0, "R3 offset wraps");
      wr(2, 3'd3, 3'd3, 32'h4000_0000, 32'hFFF0_0000, 32'h0);
      look(32'h400F_FFFF, 1'b0, 3'd3, 32'h400F_FFFF, 1'b0, 1'b0, "R4 mask top");
      look(32'h4010_0000, 1'b0, 3'd0, 32'h4010_0000, 1'b1, 1'b0, "R4 mask outside");
      wr(3, 3'd4, 3'd4, 32'h5000_0000, 32'hFFFF_0000, 32'h0100_0000);
      look(32'h5000_1234, 1'b0, 3'd4, 32'h5100_1234, 1'b0, 1'b0, "R5 mask offset");
   endtask

   task automatic t_mslice;
      wr(0, 3'd5, 3'd5, 32'h0804_0000, 32'h0000_0005, 32'h0);
      look(32'h0804_0010, 1'b0, 3'd5, 32'h0804_0010, 1'b0, 1'b0, "R6 slice0 module");
      look(32'h0804_4000, 1'b0, 3'd0, 32'h0804_4000, 1'b1, 1'b0, "R6 slice1 default");
      look(32'h0804_8000, 1'b0, 3'd5, 32'h0804_8000, 1'b0, 1'b0, "R6 slice2 module");
      look(32'h0807_FFFF, 1'b0, 3'd0, 32'h0807_FFFF, 1'b1, 1'b0, "R6 slice15 default");
      look(32'h0808_0000, 1'b0, 3'd0, 32'h0808_0000, 1'b1, 1'b0, "R6 beyond region");
   endtask

   task automatic t_io;
      wr(1, 3'd6, 3'd6, 32'h0000_03F8, 32'hFFFF_FFF8, 32'h0);
      look(32'h0000_03FF, 1'b1, 3'd6, 32'h0000_03FF, 1'b0, 1'b0, "R7 io window");
      look(32'h0000_0400, 1'b1, 3'd0, 32'h0000_0400, 1'b1, 1'b0, "R7 io outside");
      look(32'h0000_03FC, 1'b0, 3'd0, 32'h0000_03FC, 1'b1, 1'b0, "R9 io desc ignores mem");
      look(32'h4000_0000, 1'b1, 3'd0, 32'h4000_0000, 1'b1, 1'b0, "R9 mem desc ignores io");
      wr(3, 3'd7, 3'd7, 32'h0000_0060, 32'h0000_0011, 32'h0);
      look(32'h0000_0060, 1'b1, 3'd7, 32'h0000_0060, 1'b0, 1'b0, "R8 byte0 module");
      look(32'h0000_0061, 1'b1, 3'd0, 32'h0000_0061, 1'b1, 1'b0, "R8 byte1 default");
      look(32'h0000_0064, 1'b1, 3'd7, 32'h0000_0064, 1'b0, 1'b0, "R8 byte4 module");
      look(32'h0000_0068, 1'b1, 3'd0, 32'h0000_0068, 1'b1, 1'b0, "R8 next region");
   endtask

   task automatic t_priority;
      wr(0, 3'd1, 3'd1, 32'h4000_0000, 32'h4000_0FFF, 32'h0);
      look(32'h4000_0100, 1'b0, 3'd1, 32'h4000_0100, 1'b0, 1'b1, "R10 lowest wins");
      wr(0, 3'd0, 3'd1, 32'h0, 32'h0, 32'h0);
      look(32'h4000_0100, 1'b0, 3'd3, 32'h4000_0100, 1'b0, 1'b0, "R10 single owner");
   endtask

   task automatic t_same_cycle;
      set_cfg(0, 3'd1, 3'd5, 32'h4000_0000, 32'h4000_0FFF, 32'h0);
      req_addr = 32'h4000_0100; req_io = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      check_res(1'b1, 3'd3, 32'h4000_0100, 1'b0, 1'b0, "R12 same cycle old");
      look(32'h4000_0100, 1'b0, 3'd5, 32'h4000_0100, 1'b0, 1'b1, "R12 next cycle new");
   endtask

   task automatic t_idle;
      look(32'h0000_0060, 1'b1, 3'd7, 32'h0000_0060, 1'b0, 1'b0, "R11 request");
      req_addr = 32'h0010_0000; req_io = 1'b0;
      @(negedge clk);
      check_res(1'b0, 3'd7, 32'h0000_0060, 1'b0, 1'b0, "R11 idle holds");
      @(negedge clk);
      check_res(1'b0, 3'd7, 32'h0000_0060, 1'b0, 1'b0, "R11 idle holds 2");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_range();
      t_offsets();
      t_mslice();
      t_io();
      t_priority();
      t_same_cycle();
      t_idle();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung run, exp completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule